// File: doc/BRIEF.md
# TLB Control Register and Way-Replacement Unit

This block holds the control word of a 4-way set-associative translation lookaside buffer and decides which way a refill should overwrite. Software writes and reads the word through a simple register port. The word carries a translation enable, a single-address-space flag, an index-hashing select, a flush trigger and a small replacement counter. The rest of the MMU reads the enable and mode flags, the replacement way and the set index straight from the block's outputs.

When a TLB miss strobe arrives, the block looks at the valid bits of the four ways in the addressed set. If any way is empty, the counter points at the lowest-numbered empty way. If all four are full, the counter steps on by one and wraps. Any other MMU fault loads the counter with the number of the way that faulted. The set index comes from virtual address bits 16:12. In hashed mode those bits are XORed with the low five bits of the current address-space ID. A write with the flush bit set sends a one-cycle pulse that clears every valid bit in the TLB storage.

Top module: `tlb_ctl`

## Requirements
- R1: The control word has these fields: bit 0 is translation enable, bit 1 is index mode, bit 2 is flush, bits 5:4 are the replacement counter, and bit 8 is single-space mode. A write loads bits 0, 1, 4, 5 and 8 on the next clock. Every other bit reads as 0, and writes to those bits have no effect.
- R2: After reset, every field reads as 0, and the enable, mode and replacement-way outputs are 0.
- R3: On a miss strobe with all four way-valid bits set, the counter increments by one, wrapping from 3 to 0.
- R4: On a miss strobe with at least one way-valid bit clear, the counter takes the index of the lowest-numbered clear bit. Way 0 has the highest priority.
- R5: On a fault strobe (any MMU exception other than a miss), the counter takes the value on the faulting-way input. Miss and fault strobes never occur in the same cycle.
- R6: When a miss or fault update happens in the same cycle as a register write, the hardware value goes into the counter and the written counter bits are dropped. The other fields still take the written values.
- R7: `flush_pulse` is high only in the cycle of a write that has bit 2 set, and low in every other cycle. Bit 2 always reads as 0.
- R8: With index mode 0, `set_idx` equals `vaddr[16:12]`.
- R9: With index mode 1, `set_idx` equals `vaddr[16:12]` XOR `asid[4:0]`. Bits 7:5 of `asid` have no effect.
- R10: `xlat_en`, `single_space` and `repl_way` always show the current enable, single-space and counter fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| miss_evt | input | 1 | One-cycle TLB miss strobe |
| fault_evt | input | 1 | One-cycle strobe for any other MMU fault |
| fault_way | input | 2 | Way that caused the fault |
| way_valid | input | 4 | Valid bits of the four ways in the addressed set |
| vaddr | input | 32 | Virtual address |
| asid | input | 8 | Current address-space ID |
| set_idx | output | 5 | TLB set index |
| repl_way | output | 2 | Way chosen for the next refill |
| flush_pulse | output | 1 | One-cycle flush of all TLB valid bits |
| xlat_en | output | 1 | Address translation enabled |
| single_space | output | 1 | Single virtual address space mode |

## Verification
The replacement table walks the counter through a wrap from 3 to 0 and through fill patterns whose lowest empty way is 0, 1, 2 and 3. A priority encoder that favoured the highest empty way, or a counter that stepped even when a way was empty, would land on the wrong value. A fault strobe between misses checks that the counter is loaded from the faulting way and not stepped. A write that collides with a fault, and another that collides with a miss, expose a design that lets software win. Directed cases check that the flush bit reads 0 while the pulse lasts exactly one cycle. They also check that the hashed index ignores ASID bits 7:5, and that reserved bits written as 1 read back as 0.

// File: rtl/tlb_ctl_pkg.sv
package tlb_ctl_pkg;

    // Bit positions inside the control word
    localparam int F_AT    = 0;
    localparam int F_IXM   = 1;
    localparam int F_FLUSH = 2;
    localparam int F_RC_LO = 4;
    localparam int F_SVM   = 8;

    // Source of the next replacement-counter value
    typedef enum logic [1:0] {
        RC_KEEP = 2'd0,
        RC_STEP = 2'd1,
        RC_FILL = 2'd2,
        RC_LOAD = 2'd3
    } rc_src_e;

endpackage

// File: rtl/tlb_way_pick.sv
module tlb_way_pick
    import tlb_ctl_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int RC_W = $clog2(WAYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WAYS-1:0] way_valid,
    input  logic [RC_W-1:0] rc_cur,
    input  logic            miss_i,
    input  logic            fault_i,
    input  logic [RC_W-1:0] fault_way_i,
    output rc_src_e         rc_src,
    output logic [RC_W-1:0] rc_next
);

    localparam logic [RC_W-1:0] LAST_WAY = RC_W'(WAYS - 1);

    logic [RC_W-1:0] first_free;
    logic            any_free;
    logic [RC_W-1:0] stepped;

    // Find the lowest-numbered empty way; scan downwards so the lowest index wins.
    always_comb begin
        first_free = '0;
        any_free   = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) begin
                first_free = RC_W'(w);
                any_free   = 1'b1;
            end
        end
    end

    assign stepped = (rc_cur == LAST_WAY) ? '0 : rc_cur + 1'b1;

    always_comb begin
        rc_src  = RC_KEEP;
        rc_next = rc_cur;
        if (fault_i) begin
            rc_src  = RC_LOAD;
            rc_next = fault_way_i;
        end else if (miss_i && any_free) begin
            rc_src  = RC_FILL;
            rc_next = first_free;
        end else if (miss_i) begin
            rc_src  = RC_STEP;
            rc_next = stepped;
        end
    end

    AST_FILL_TARGET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_src == RC_FILL) |-> !way_valid[rc_next]);                       // R4
    AST_STEP_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_src == RC_STEP) |-> (&way_valid));                              // R3

endmodule

// File: rtl/tlb_set_index.sv
module tlb_set_index #(
    parameter int VA_W    = 32,
    parameter int ASID_W  = 8,
    parameter int IDX_W   = 5,
    parameter int IDX_LSB = 12
) (
    input  logic [VA_W-1:0]   vaddr,
    input  logic [ASID_W-1:0] asid,
    input  logic              hash_mode,
    output logic [IDX_W-1:0]  set_idx
);

    logic [IDX_W-1:0] va_field;
    logic [IDX_W-1:0] asid_field;

    assign va_field = vaddr[IDX_LSB +: IDX_W];

    generate
        if (ASID_W >= IDX_W) begin : g_asid_wide
            assign asid_field = asid[IDX_W-1:0];
        end else begin : g_asid_narrow
            assign asid_field = {{(IDX_W-ASID_W){1'b0}}, asid};
        end
    endgenerate

    assign set_idx = hash_mode ? (va_field ^ asid_field) : va_field;

endmodule

// File: rtl/tlb_ctl.sv
module tlb_ctl
    import tlb_ctl_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int WAYS    = 4,
    parameter int VA_W    = 32,
    parameter int ASID_W  = 8,
    parameter int IDX_W   = 5,
    parameter int IDX_LSB = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              miss_evt,
    input  logic              fault_evt,
    input  logic [1:0]        fault_way,
    input  logic [WAYS-1:0]   way_valid,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [ASID_W-1:0] asid,
    output logic [IDX_W-1:0]  set_idx,
    output logic [1:0]        repl_way,
    output logic              flush_pulse,
    output logic              xlat_en,
    output logic              single_space
);

    localparam int RC_W = $clog2(WAYS);

    typedef struct packed {
        logic            svm;
        logic [RC_W-1:0] rc;
        logic            ixm;
        logic            at;
    } ctl_t;

    ctl_t            ctl_d, ctl_q;
    rc_src_e         rc_src;
    logic [RC_W-1:0] rc_next;

    tlb_way_pick #(.WAYS(WAYS), .RC_W(RC_W)) u_way_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .way_valid   (way_valid),
        .rc_cur      (ctl_q.rc),
        .miss_i      (miss_evt),
        .fault_i     (fault_evt),
        .fault_way_i (fault_way[RC_W-1:0]),
        .rc_src      (rc_src),
        .rc_next     (rc_next)
    );

    tlb_set_index #(
        .VA_W(VA_W), .ASID_W(ASID_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)
    ) u_set_index (
        .vaddr     (vaddr),
        .asid      (asid),
        .hash_mode (ctl_q.ixm),
        .set_idx   (set_idx)
    );

    // Next-state computation: software write first, then the hardware update overrides the counter.
    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d.svm = wr_data[F_SVM];
            ctl_d.rc  = wr_data[F_RC_LO +: RC_W];
            ctl_d.ixm = wr_data[F_IXM];
            ctl_d.at  = wr_data[F_AT];
        end
        if (rc_src != RC_KEEP) begin
            ctl_d.rc = rc_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        rd_data                     = '0;
        rd_data[F_SVM]              = ctl_q.svm;
        rd_data[F_RC_LO +: RC_W]    = ctl_q.rc;
        rd_data[F_IXM]              = ctl_q.ixm;
        rd_data[F_AT]               = ctl_q.at;
    end

    assign flush_pulse  = wr_en & wr_data[F_FLUSH];
    assign xlat_en      = ctl_q.at;
    assign single_space = ctl_q.svm;
    assign repl_way     = 2'(ctl_q.rc);

    AST_RC_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_evt && (&way_valid)) |=> (repl_way == 2'($past(repl_way) + 2'd1)));   // R3
    AST_RC_FILL_WAY0: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_evt && !way_valid[0]) |=> (repl_way == 2'd0));                        // R4
    AST_RC_FAULT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        fault_evt |=> (repl_way == $past(fault_way)));                             // R5
    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(miss_evt && fault_evt));                                                 // R5
    AST_SW_RC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !miss_evt && !fault_evt) |=> (rd_data[5:4] == $past(wr_data[5:4]))); // R1
    AST_FLUSH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> wr_en);                                                    // R7
    AST_FLUSH_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[F_FLUSH] == 1'b0);                                                 // R7

endmodule

// File: tb/tlb_ctl_bench.sv
`timescale 1ns/1ps
module tlb_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        miss_evt = 1'b0;
    logic        fault_evt = 1'b0;
    logic [1:0]  fault_way = '0;
    logic [3:0]  way_valid = '0;
    logic [31:0] vaddr = '0;
    logic [7:0]  asid = '0;
    logic [4:0]  set_idx;
    logic [1:0]  repl_way;
    logic        flush_pulse;
    logic        xlat_en;
    logic        single_space;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    tlb_ctl u_tlb_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .miss_evt(miss_evt), .fault_evt(fault_evt), .fault_way(fault_way),
        .way_valid(way_valid), .vaddr(vaddr), .asid(asid), .set_idx(set_idx),
        .repl_way(repl_way), .flush_pulse(flush_pulse), .xlat_en(xlat_en),
        .single_space(single_space)
    );

    // Entry: [8] 0=miss 1=fault, [7:4] way valid, [3:2] faulting way, [1:0] expected counter
    localparam logic [8:0] VEC [14] = '{
        {1'b0, 4'b1111, 2'd0, 2'd1},
        {1'b0, 4'b1111, 2'd0, 2'd2},
        {1'b0, 4'b1111, 2'd0, 2'd3},
        {1'b0, 4'b1111, 2'd0, 2'd0},
        {1'b0, 4'b1110, 2'd0, 2'd0},
        {1'b0, 4'b1101, 2'd0, 2'd1},
        {1'b0, 4'b0011, 2'd0, 2'd2},
        {1'b0, 4'b0111, 2'd0, 2'd3},
        {1'b0, 4'b0100, 2'd0, 2'd0},
        {1'b1, 4'b1111, 2'd2, 2'd2},
        {1'b0, 4'b1111, 2'd0, 2'd3},
        {1'b1, 4'b0000, 2'd1, 2'd1},
        {1'b0, 4'b1011, 2'd0, 2'd2},
        {1'b0, 4'b1111, 2'd0, 2'd3}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    task automatic reg_write(input logic [31:0] val);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = val;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        chk("R2 rd_data", rd_data, 32'h0);
        chk("R2 outputs", {29'b0, xlat_en, single_space, 1'b0}, 32'h0);
        chk("R2 repl_way", {30'b0, repl_way}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R4/R5: replacement table
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            way_valid = VEC[i][7:4];
            fault_way = VEC[i][3:2];
            miss_evt  = ~VEC[i][8];
            fault_evt = VEC[i][8];
            @(negedge clk);
            miss_evt  = 1'b0;
            fault_evt = 1'b0;
            if (VEC[i][8])
                chk("R5 fault load", {30'b0, repl_way}, {30'b0, VEC[i][1:0]});
            else if (VEC[i][7:4] == 4'b1111)
                chk("R3 step", {30'b0, repl_way}, {30'b0, VEC[i][1:0]});
            else
                chk("R4 fill", {30'b0, repl_way}, {30'b0, VEC[i][1:0]});
        end

        // R1/R7/R10: write all ones, flush pulse in the write cycle
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 32'hFFFF_FFFF;
        #1;
        chk("R7 flush high", {31'b0, flush_pulse}, 32'h1);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
        #1;
        chk("R7 flush low", {31'b0, flush_pulse}, 32'h0);
        chk("R1 readback reserved", rd_data, 32'h0000_0133);
        chk("R10 xlat_en", {31'b0, xlat_en}, 32'h1);
        chk("R10 single_space", {31'b0, single_space}, 32'h1);
        chk("R10 repl_way", {30'b0, repl_way}, 32'h3);

        // R9: hashed index, upper ASID bits ignored
        vaddr = 32'h0001_6000;
        asid  = 8'hE5;
        #1;
        chk("R9 hashed", {27'b0, set_idx}, {27'b0, 5'b10110 ^ 5'b00101});
        asid  = 8'h05;
        #1;
        chk("R9 asid high ignored", {27'b0, set_idx}, {27'b0, 5'b10011});

        // R8: plain index
        reg_write(32'h0000_0000);
        #1;
        chk("R8 plain", {27'b0, set_idx}, 32'h16);
        chk("R1 cleared", rd_data, 32'h0);
        chk("R7 flush idle", {31'b0, flush_pulse}, 32'h0);

        // R6: fault beats software write of the counter field
        @(negedge clk);
        wr_en     = 1'b1;
        wr_data   = 32'h0000_0031;
        fault_evt = 1'b1;
        fault_way = 2'd1;
        @(negedge clk);
        wr_en     = 1'b0;
        wr_data   = '0;
        fault_evt = 1'b0;
        chk("R6 fault wins", rd_data, 32'h0000_0011);

        // R6: miss with full set beats software write
        @(negedge clk);
        wr_en     = 1'b1;
        wr_data   = 32'h0000_0000;
        miss_evt  = 1'b1;
        way_valid = 4'b1111;
        @(negedge clk);
        wr_en     = 1'b0;
        miss_evt  = 1'b0;
        chk("R6 miss wins", rd_data, 32'h0000_0020);

        finish_run();
    end

endmodule